// File: doc/BRIEF.md
# Head-and-tail bundle instruction extractor

This block takes one 128-bit instruction bundle and splits it into as many as eight aligned instructions in a single pass. In this format each instruction has a fixed 10-bit head and a variable tail of one to five 5-bit units. The heads sit at the front of the bundle in instruction order. The tails are packed from the far end of the bundle toward the heads, so the first instruction's tail is the last thing in the bundle. Because every head is at a fixed place, all heads are length-decoded at the same time. The only serial work is the chain of additions that finds where each tail starts.

A fetch stage presents a bundle with a valid strobe. One clock later the block presents a registered vector of instruction slots. Each slot carries its head, its tail right-aligned unit by unit, its tail unit count and a valid flag. The block also reports the number of instructions and an overlap error flag. When the strobe is low, every registered output keeps its value, except the output strobe.

Top module: `hat_bundle_extract`

## Requirements
- R1: Bits [127:125] of the bundle hold the index of the last instruction. The 5-bit unit k (k = 0..24) is held in bits [124-5k -: 5]. The head of instruction i is bits [124-10i -: 10], which covers units 2i and 2i+1. Slot i of `inst_head` (bits [10i +: 10]) shows this head.
- R2: The tail unit count of an instruction is (op mod 5) + 1, where op is the upper 5 bits [9:5] of its head. The count is shown in slot i of `inst_tlen` (bits [3i +: 3]).
- R3: Let S_i be the sum of the tail counts of instructions 0..i-1, and L_i the tail count of instruction i. The tail of instruction i occupies units 25-S_i-L_i through 24-S_i. Tail unit j appears in bits [25i+5j +: 5] of `inst_tail` and equals unit 25-S_i-L_i+j. Tail positions j >= L_i are zero.
- R4: `out_count` equals the last-index field plus 1. Slots with an index above the last-index field have a `inst_vld` bit of 0, and their head, tail and tail count are zero.
- R5: `out_error` is 1 when 2*count plus the sum of the tail counts of the counted instructions is greater than 25. When it is 1, every slot is invalid and zero, and `out_count` is still reported.
- R6: The outputs load on a rising edge where `in_valid` is 1. `out_valid` is 1 in exactly the cycle after each such edge.
- R7: While `in_valid` is 0, the slot outputs, `out_count` and `out_error` hold their values, whatever is on `in_bundle`.
- R8: A synchronous active-high `rst` clears every output to zero.
- R9: A bundle whose heads and tails fill all 25 units exactly raises no error. Units that lie between the last head and the last tail have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Bundle strobe |
| in_bundle | input | 128 | Instruction bundle |
| out_valid | output | 1 | Outputs were loaded on the last edge |
| out_count | output | 4 | Number of instructions in the bundle |
| out_error | output | 1 | Heads and tails overlap |
| inst_vld | output | 8 | Per-slot valid flag |
| inst_head | output | 80 | Per-slot 10-bit head |
| inst_tail | output | 200 | Per-slot tail, five 5-bit units |
| inst_tlen | output | 24 | Per-slot 3-bit tail unit count |

## Verification
The bench builds random bundles whose opcodes are chosen to fit the space, mixes them with raw random bundles that mostly overflow, and adds directed cases.

- **Exact fill:** a bundle that fills all 25 units must give no error. A design with an off-by-one in the overlap compare would flag it wrongly.
- **One unit over:** a bundle that needs 26 units must raise the error. A design with the wrong compare would pass its slots through.
- **Eight one-unit tails:** a design that misorders the tail chain or counts from the wrong end would return shifted tails.
- **Garbage in the gap:** rewriting the free units, and changing the bundle while the strobe is low, must leave every output unchanged. A design that leaks gap bits into a tail, or loads without the strobe, would show it.

// File: rtl/hat_pkg.sv
package hat_pkg;
  localparam int UNIT_W     = 5;
  localparam int N_UNITS    = 25;
  localparam int HEAD_UNITS = 2;
  localparam int MAX_INST   = 8;
  localparam int TAIL_MAX   = 5;
  localparam int IDX_W      = 3;
  localparam int OP_W       = 5;
  localparam int BUNDLE_W   = IDX_W + N_UNITS * UNIT_W;
  localparam int HEAD_W     = HEAD_UNITS * UNIT_W;
  localparam int TAIL_W     = TAIL_MAX * UNIT_W;
  localparam int LEN_W      = $clog2(TAIL_MAX + 1);
  localparam int CNT_W      = $clog2(MAX_INST + 1);
  localparam int SUM_W      = $clog2(MAX_INST * TAIL_MAX + N_UNITS + 1) + 1;

  // Opcode to tail-length table, computed rather than listed.
  function automatic logic [LEN_W-1:0] op_tail_len(input logic [OP_W-1:0] op);
    return LEN_W'((int'(op) % TAIL_MAX) + 1);
  endfunction
endpackage

// File: rtl/hat_len_dec.sv
module hat_len_dec
  import hat_pkg::*;
#(
  parameter int NI  = MAX_INST,
  parameter int OPW = OP_W,
  parameter int LW  = LEN_W
) (
  input  logic [NI*OPW-1:0] ops_i,
  input  logic [NI-1:0]     active_i,
  output logic [NI*LW-1:0]  lens_o
);
  // One independent decoder per head, no dependence between slots.
  for (genvar g = 0; g < NI; g++) begin : g_dec
    logic [LW-1:0] len_raw;
    assign len_raw = LW'(op_tail_len(OP_W'(ops_i[g*OPW +: OPW])));
    assign lens_o[g*LW +: LW] = active_i[g] ? len_raw : '0;
  end
endmodule

// File: rtl/hat_tail_chain.sv
module hat_tail_chain #(
  parameter int NI    = 8,
  parameter int LW    = 3,
  parameter int SW    = 8,
  parameter int NU    = 25,
  parameter int HU    = 2,
  parameter int CW    = 4
) (
  input  logic [NI*LW-1:0] lens_i,
  input  logic [CW-1:0]    count_i,
  output logic [NI*SW-1:0] start_o,
  output logic             overlap_o
);
  logic [SW-1:0] acc;
  logic [SW-1:0] head_units;

  // Serial chain: each tail begins just below the previous ones.
  always_comb begin
    acc = '0;
    for (int i = 0; i < NI; i++) begin
      start_o[i*SW +: SW] = SW'(NU) - acc - SW'(lens_i[i*LW +: LW]);
      acc = acc + SW'(lens_i[i*LW +: LW]);
    end
    head_units = SW'(HU) * SW'(count_i);
    overlap_o  = (head_units + acc) > SW'(NU);
  end
endmodule

// File: rtl/hat_tail_extract.sv
module hat_tail_extract #(
  parameter int UW = 5,
  parameter int NU = 25,
  parameter int TM = 5,
  parameter int LW = 3,
  parameter int SW = 8
) (
  input  logic [NU*UW-1:0] units_i,
  input  logic [SW-1:0]    start_i,
  input  logic [LW-1:0]    len_i,
  output logic [TM*UW-1:0] tail_o
);
  always_comb begin
    tail_o = '0;
    for (int j = 0; j < TM; j++) begin
      if (LW'(j) < len_i) begin
        for (int u = 0; u < NU; u++) begin
          if (start_i + SW'(j) == SW'(u))
            tail_o[j*UW +: UW] = units_i[u*UW +: UW];
        end
      end
    end
  end
endmodule

// File: rtl/hat_bundle_extract.sv
module hat_bundle_extract
  import hat_pkg::*;
#(
  parameter int NI = MAX_INST,
  parameter int BW = BUNDLE_W,
  parameter int HW = HEAD_W,
  parameter int TW = TAIL_W,
  parameter int LW = LEN_W,
  parameter int CW = CNT_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [BW-1:0]  in_bundle,
  output logic           out_valid,
  output logic [CW-1:0]  out_count,
  output logic           out_error,
  output logic [NI-1:0]  inst_vld,
  output logic [NI*HW-1:0] inst_head,
  output logic [NI*TW-1:0] inst_tail,
  output logic [NI*LW-1:0] inst_tlen
);
  localparam int UNITS_TOP = BW - IDX_W - 1;

  logic [IDX_W-1:0]        last_idx;
  logic [CW-1:0]           count_c;
  logic [N_UNITS*UNIT_W-1:0] units;
  logic [NI*HW-1:0]        heads;
  logic [NI*OP_W-1:0]      ops;
  logic [NI-1:0]           active;
  logic [NI*LW-1:0]        lens;
  logic [NI*SUM_W-1:0]     starts;
  logic [NI*TW-1:0]        tails;
  logic                    overlap;

  assign last_idx = in_bundle[BW-1 -: IDX_W];
  assign count_c  = CW'(last_idx) + CW'(1);

  for (genvar k = 0; k < N_UNITS; k++) begin : g_unit
    assign units[k*UNIT_W +: UNIT_W] = in_bundle[UNITS_TOP - UNIT_W*k -: UNIT_W];
  end

  for (genvar g = 0; g < NI; g++) begin : g_head
    assign heads[g*HW +: HW]    = in_bundle[UNITS_TOP - HW*g -: HW];
    assign ops[g*OP_W +: OP_W]  = heads[g*HW + HW - 1 -: OP_W];
    assign active[g]            = (g <= int'(last_idx));
  end

  hat_len_dec #(.NI(NI), .OPW(OP_W), .LW(LW)) i_len_dec (
    .ops_i    (ops),
    .active_i (active),
    .lens_o   (lens)
  );

  hat_tail_chain #(
    .NI(NI), .LW(LW), .SW(SUM_W), .NU(N_UNITS), .HU(HEAD_UNITS), .CW(CW)
  ) i_chain (
    .lens_i    (lens),
    .count_i   (count_c),
    .start_o   (starts),
    .overlap_o (overlap)
  );

  for (genvar g = 0; g < NI; g++) begin : g_tail
    hat_tail_extract #(
      .UW(UNIT_W), .NU(N_UNITS), .TM(TAIL_MAX), .LW(LW), .SW(SUM_W)
    ) i_ext (
      .units_i (units),
      .start_i (starts[g*SUM_W +: SUM_W]),
      .len_i   (lens[g*LW +: LW]),
      .tail_o  (tails[g*TW +: TW])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_count <= '0;
      out_error <= 1'b0;
      inst_vld  <= '0;
      inst_head <= '0;
      inst_tail <= '0;
      inst_tlen <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_count <= count_c;
        out_error <= overlap;
        for (int i = 0; i < NI; i++) begin
          if (active[i] && !overlap) begin
            inst_vld[i]          <= 1'b1;
            inst_head[i*HW +: HW] <= heads[i*HW +: HW];
            inst_tail[i*TW +: TW] <= tails[i*TW +: TW];
            inst_tlen[i*LW +: LW] <= lens[i*LW +: LW];
          end else begin
            inst_vld[i]          <= 1'b0;
            inst_head[i*HW +: HW] <= '0;
            inst_tail[i*TW +: TW] <= '0;
            inst_tlen[i*LW +: LW] <= '0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/hat_bundle_extract_chk.sv
module hat_bundle_extract_chk
  import hat_pkg::*;
#(
  parameter int NI = MAX_INST,
  parameter int BW = BUNDLE_W,
  parameter int HW = HEAD_W,
  parameter int TW = TAIL_W,
  parameter int LW = LEN_W,
  parameter int CW = CNT_W
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic [BW-1:0]  in_bundle,
  input logic           out_valid,
  input logic [CW-1:0]  out_count,
  input logic           out_error,
  input logic [NI-1:0]  inst_vld,
  input logic [NI*HW-1:0] inst_head,
  input logic [NI*TW-1:0] inst_tail,
  input logic [NI*LW-1:0] inst_tlen
);
  p_latency_r6: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_idle_r6: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  p_count_r4: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_count == CW'($past(in_bundle[BW-1 -: IDX_W])) + CW'(1));
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(inst_head) && $stable(inst_tail) &&
                   $stable(out_count) && $stable(out_error)));
  p_err_empty_r5: assert property (@(posedge clk) disable iff (rst)
    out_error |-> inst_vld == '0);
  p_vld_count_r4: assert property (@(posedge clk) disable iff (rst)
    !out_error |-> $countones(inst_vld) == int'(out_count));
  p_reset_r8: assert property (@(posedge clk)
    rst |=> (!out_valid && out_count == '0 && inst_vld == '0));

  for (genvar g = 0; g < NI; g++) begin : g_slot
    p_tlen_range_r2: assert property (@(posedge clk) disable iff (rst)
      inst_vld[g] |-> (inst_tlen[g*LW +: LW] >= LW'(1) &&
                       inst_tlen[g*LW +: LW] <= LW'(TAIL_MAX)));
    p_idle_zero_r4: assert property (@(posedge clk) disable iff (rst)
      !inst_vld[g] |-> (inst_head[g*HW +: HW] == '0 &&
                        inst_tail[g*TW +: TW] == '0 &&
                        inst_tlen[g*LW +: LW] == '0));
  end
endmodule

bind hat_bundle_extract hat_bundle_extract_chk i_chk (.*);

// File: tb/test_hat_bundle_extract.sv
`timescale 1ns/1ps
module test_hat_bundle_extract;
  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic [127:0] in_bundle;
  logic         out_valid;
  logic [3:0]   out_count;
  logic         out_error;
  logic [7:0]   inst_vld;
  logic [79:0]  inst_head;
  logic [199:0] inst_tail;
  logic [23:0]  inst_tlen;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  hat_bundle_extract i_hat_bundle_extract (.*);

  task automatic check(input string req, input string what,
                       input logic [199:0] act, input logic [199:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Reference model written from the requirements.
  task automatic model(input logic [127:0] b, output logic [3:0] cnt,
                       output logic err, output logic [7:0] vld,
                       output logic [79:0] hd, output logic [199:0] tl,
                       output logic [23:0] tn);
    int n, s, st;
    int len [8];
    int pre [8];
    logic [9:0] h;
    n = int'(b[127:125]) + 1;
    cnt = 4'(n);
    s = 0;
    for (int i = 0; i < n; i++) begin
      h = b[124-10*i -: 10];
      len[i] = (int'(h[9:5]) % 5) + 1;
      pre[i] = s;
      s += len[i];
    end
    err = (2*n + s) > 25;
    vld = '0; hd = '0; tl = '0; tn = '0;
    if (!err) begin
      for (int i = 0; i < n; i++) begin
        vld[i] = 1'b1;
        hd[10*i +: 10] = b[124-10*i -: 10];
        tn[3*i +: 3] = 3'(len[i]);
        st = 25 - pre[i] - len[i];
        for (int j = 0; j < len[i]; j++)
          tl[25*i + 5*j +: 5] = b[124-5*(st+j) -: 5];
      end
    end
  endtask

  task automatic send(input logic [127:0] b);
    @(negedge clk);
    in_valid  = 1'b1;
    in_bundle = b;
    @(negedge clk);
    in_valid  = 1'b0;
  endtask

  task automatic compare(input logic [127:0] b);
    logic [3:0] c; logic e; logic [7:0] v;
    logic [79:0] h; logic [199:0] t; logic [23:0] n;
    model(b, c, e, v, h, t, n);
    check("R6", "out_valid", 200'(out_valid), 200'(1));
    check("R4", "count", 200'(out_count), 200'(c));
    check("R5", "error", 200'(out_error), 200'(e));
    check("R4", "vld", 200'(inst_vld), 200'(v));
    check("R1", "head", 200'(inst_head), 200'(h));
    check("R2", "tlen", 200'(inst_tlen), 200'(n));
    check("R3", "tail", inst_tail, t);
  endtask

  // Bundle with chosen tail lengths (entries 0 mean random that fits).
  function automatic logic [127:0] build(input int n, input int lens [8]);
    logic [127:0] b;
    int budget, l, m;
    b = {$urandom, $urandom, $urandom, $urandom};
    b[127:125] = 3'(n - 1);
    budget = 25 - 2*n;
    for (int i = 0; i < n; i++) begin
      l = lens[i];
      if (l == 0) begin
        m = budget - (n - 1 - i);
        if (m > 5) m = 5;
        l = 1 + int'($urandom % 32'(m));
      end
      budget -= l;
      m = int'($urandom % 6);
      b[124-10*i -: 5] = 5'((l - 1) + 5*m);
    end
    return b;
  endfunction

  initial begin
    #(5.0 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int lz [8];
    int lv [8];
    logic [127:0] b, b2;
    logic [199:0] snap_t; logic [79:0] snap_h;
    void'($urandom(32'd1234));
    lz = '{default: 0};
    rst = 1'b1; in_valid = 1'b0; in_bundle = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8 reset state
    check("R8", "reset out_valid", 200'(out_valid), 200'(0));
    check("R8", "reset count", 200'(out_count), 200'(0));
    check("R8", "reset slots", {inst_tail[199:112], inst_head, inst_tlen, inst_vld}, '0);

    // R9 exact fill: five heads, tails 3 each -> 10 + 15 = 25
    lv = '{3, 3, 3, 3, 3, 0, 0, 0};
    b = build(5, lv);
    send(b); compare(b);
    check("R9", "exact fill error", 200'(out_error), 200'(0));
    // R5 one unit over
    lv = '{3, 3, 3, 3, 4, 0, 0, 0};
    b = build(5, lv);
    send(b); compare(b);
    check("R5", "overflow error", 200'(out_error), 200'(1));
    // R3 eight one-unit tails
    lv = '{1, 1, 1, 1, 1, 1, 1, 1};
    b = build(8, lv);
    send(b); compare(b);
    // single five-unit tail
    lv = '{5, 0, 0, 0, 0, 0, 0, 0};
    b = build(1, lv);
    send(b); compare(b);

    // R9 gap units ignored: 2 insts len 2 -> units 4..20 free
    lv = '{2, 2, 0, 0, 0, 0, 0, 0};
    b = build(2, lv);
    send(b); compare(b);
    snap_t = inst_tail; snap_h = inst_head;
    b2 = b;
    for (int k = 4; k <= 20; k++) b2[124-5*k -: 5] = ~b2[124-5*k -: 5];
    send(b2);
    check("R9", "gap tail", inst_tail, snap_t);
    check("R9", "gap head", 200'(inst_head), 200'(snap_h));

    // R7 hold while strobe low, R6 strobe drops
    @(negedge clk);
    in_bundle = ~b;
    @(negedge clk);
    check("R6", "out_valid idle", 200'(out_valid), 200'(0));
    check("R7", "hold tail", inst_tail, snap_t);
    check("R7", "hold head", 200'(inst_head), 200'(snap_h));

    // Random fitting bundles and raw bundles
    for (int r = 0; r < 150; r++) begin
      b = build(1 + int'($urandom % 8), lz);
      send(b); compare(b);
    end
    for (int r = 0; r < 60; r++) begin
      b = {$urandom, $urandom, $urandom, $urandom};
      send(b); compare(b);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule